// File: doc/BRIEF.md
# Floating-Point Result Writeback Arbiter

This block sits between a set of floating-point execution pipes and the tagged register files of their requesters. Each pipe presents one finished result per handshake: the requester (source) it belongs to, a base register number, which machine word of a multi-word result is being returned, the result length in words, and the full-width result value. For every source, the block picks one pipe and works out the destination register. It looks up that register's current tag, asks the source's register file for a write port, and commits one word with the FULL tag.

A pipe keeps its request asserted until it sees `pipe_ready` high. The block raises `pipe_ready` only in the cycle that its write is committed. It holds the pipe back if another pipe wins the same source, if the write port is refused, or if the destination has not yet been marked as awaiting a result. The committed write leaves the block on the source's registered write port one clock later. A parameter selects little- or big-endian word numbering within a multi-word result.

Top module: `fp_result_writeback`

## Requirements
- R1: The destination register number is the pipe's base plus its word index, modulo 2^ADDR_W. It is driven on the source's `rf_rd_addr` in the same cycle and on `rf_wr_addr` with the write.
- R2: With `BIG_ENDIAN=0`, the written word is bits [WORD_W*(i+1)-1 : WORD_W*i] of the result value, where i is the word index.
- R3: With `BIG_ENDIAN=1`, the written word is taken at effective index (size - 1 - i), where size is the result length in words.
- R4: A write commits only when the destination tag on `rf_rd_tag` is PENDING (2'd1) or WAITING (2'd2). EMPTY (2'd0) and FULL (2'd3) stall the pipe, and no write is issued.
- R5: `rf_wr_req` of a source is high whenever a valid pipe targets that source. A write commits only if `rf_wr_gnt` of that source is high in the same cycle; otherwise the pipe stalls.
- R6: Per source, at most one pipe commits per cycle. Among the valid pipes naming that source, the lowest-numbered one is the only candidate.
- R7: Pipes naming different sources are served independently in the same cycle.
- R8: `pipe_ready` is high only in the cycle its write commits. On the next clock edge the source's `rf_wr_en` pulses for one cycle, with the word on `rf_wr_data` and tag FULL (2'd3) on `rf_wr_tag`. `rf_wr_en` is never high otherwise.
- R9: While `rst_n` is low, `rf_wr_en` stays low on every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_valid | input | NUM_PIPES | Result offered by each pipe |
| pipe_src | input | NUM_PIPES*SRC_W | Source number per pipe |
| pipe_base | input | NUM_PIPES*ADDR_W | Base register number per pipe |
| pipe_index | input | NUM_PIPES*IDX_W | Word index within the result |
| pipe_size | input | NUM_PIPES*SIZE_W | Result length in words (1..MAX_WORDS) |
| pipe_value | input | NUM_PIPES*RES_W | Full-width result value |
| pipe_ready | output | NUM_PIPES | Result accepted this cycle |
| rf_rd_addr | output | NUM_SOURCES*ADDR_W | Destination whose tag is looked up |
| rf_rd_tag | input | NUM_SOURCES*2 | Current tag of that destination |
| rf_wr_req | output | NUM_SOURCES | Write port request |
| rf_wr_gnt | input | NUM_SOURCES | Write port granted |
| rf_wr_en | output | NUM_SOURCES | Registered write strobe |
| rf_wr_addr | output | NUM_SOURCES*ADDR_W | Registered write register number |
| rf_wr_data | output | NUM_SOURCES*WORD_W | Registered write word |
| rf_wr_tag | output | NUM_SOURCES*2 | Tag written, always FULL |

## Verification
The handshake and lookup outputs (`pipe_ready`, `rf_rd_addr`, `rf_wr_req`) are combinational on the inputs. They are due in the same cycle as the stimulus, and the bench samples them one nanosecond after driving it. The write port passes through one register, so `rf_wr_en`, address, data and tag are due at the next rising edge. The bench samples them at the following falling edge, before it drives the next stimulus. Two instances share every stimulus, one per word order, so each vector checks both extractions.

// File: rtl/wb_pkg.sv
package wb_pkg;

  typedef enum logic [1:0] {
    TAG_EMPTY   = 2'd0,
    TAG_PENDING = 2'd1,
    TAG_WAITING = 2'd2,
    TAG_FULL    = 2'd3
  } reg_tag_e;

  // A result may land only on a register that is expecting one.
  function automatic logic tag_accepts(input logic [1:0] t);
    return (t == TAG_PENDING) || (t == TAG_WAITING);
  endfunction

endpackage

// File: rtl/wb_prio_pick.sv
module wb_prio_pick #(
  parameter int N = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  logic found;

  always_comb begin
    gnt   = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
        found  = 1'b1;
      end
    end
    any = found;
  end

endmodule

// File: rtl/wb_word_extract.sv
module wb_word_extract #(
  parameter int WORD_W     = 32,
  parameter int MAX_WORDS  = 4,
  parameter int ADDR_W     = 6,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int IDX_W  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int SIZE_W = $clog2(MAX_WORDS + 1),
  localparam int RES_W  = WORD_W * MAX_WORDS
) (
  input  logic [RES_W-1:0]  value,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  index,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] dest,
  output logic [WORD_W-1:0] word
);

  function automatic logic [IDX_W-1:0] eff_index(input logic [IDX_W-1:0] i,
                                                 input logic [SIZE_W-1:0] sz);
    logic [SIZE_W-1:0] r;
    if (BIG_ENDIAN) begin
      r = sz - SIZE_W'(1) - SIZE_W'(i);
      return r[IDX_W-1:0];
    end
    return i;
  endfunction

  function automatic logic [WORD_W-1:0] word_at(input logic [RES_W-1:0] v,
                                                input logic [IDX_W-1:0] e);
    logic [RES_W-1:0] sh;
    sh = v >> (WORD_W * int'(e));
    return sh[WORD_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] dest_reg(input logic [ADDR_W-1:0] b,
                                                 input logic [IDX_W-1:0] i);
    return b + ADDR_W'(i);
  endfunction

  assign dest = dest_reg(base, index);
  assign word = word_at(value, eff_index(index, size));

endmodule

// File: rtl/wb_commit_reg.sv
module wb_commit_reg #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= commit;
      if (commit) begin
        wr_addr <= addr;
        wr_data <= word;
      end
    end
  end

endmodule

// File: rtl/fp_result_writeback.sv
module fp_result_writeback #(
  parameter int NUM_PIPES   = 3,
  parameter int NUM_SOURCES = 2,
  parameter int WORD_W      = 32,
  parameter int MAX_WORDS   = 4,
  parameter int ADDR_W      = 6,
  parameter bit BIG_ENDIAN  = 1'b0,
  localparam int SRC_W  = (NUM_SOURCES > 1) ? $clog2(NUM_SOURCES) : 1,
  localparam int IDX_W  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int SIZE_W = $clog2(MAX_WORDS + 1),
  localparam int RES_W  = WORD_W * MAX_WORDS,
  localparam int PIDX_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PIPES-1:0]          pipe_valid,
  input  logic [NUM_PIPES*SRC_W-1:0]    pipe_src,
  input  logic [NUM_PIPES*ADDR_W-1:0]   pipe_base,
  input  logic [NUM_PIPES*IDX_W-1:0]    pipe_index,
  input  logic [NUM_PIPES*SIZE_W-1:0]   pipe_size,
  input  logic [NUM_PIPES*RES_W-1:0]    pipe_value,
  output logic [NUM_PIPES-1:0]          pipe_ready,
  output logic [NUM_SOURCES*ADDR_W-1:0] rf_rd_addr,
  input  logic [NUM_SOURCES*2-1:0]      rf_rd_tag,
  output logic [NUM_SOURCES-1:0]        rf_wr_req,
  input  logic [NUM_SOURCES-1:0]        rf_wr_gnt,
  output logic [NUM_SOURCES-1:0]        rf_wr_en,
  output logic [NUM_SOURCES*ADDR_W-1:0] rf_wr_addr,
  output logic [NUM_SOURCES*WORD_W-1:0] rf_wr_data,
  output logic [NUM_SOURCES*2-1:0]      rf_wr_tag
);
  import wb_pkg::*;

  // Named internal events
  logic [NUM_SOURCES-1:0] commit_ev;
  logic [NUM_PIPES-1:0]   grant_mat [NUM_SOURCES];

  for (genvar s = 0; s < NUM_SOURCES; s++) begin : g_src
    logic [NUM_PIPES-1:0] match;
    logic [NUM_PIPES-1:0] gsel;
    logic                 any;
    logic [PIDX_W-1:0]    win;
    logic [ADDR_W-1:0]    dest;
    logic [WORD_W-1:0]    word;

    always_comb begin
      for (int p = 0; p < NUM_PIPES; p++) begin
        match[p] = pipe_valid[p] && (pipe_src[p*SRC_W +: SRC_W] == SRC_W'(s));
      end
    end

    wb_prio_pick #(.N(NUM_PIPES)) u_pick (
      .req (match),
      .gnt (gsel),
      .any (any),
      .idx (win)
    );

    wb_word_extract #(
      .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS),
      .ADDR_W(ADDR_W), .BIG_ENDIAN(BIG_ENDIAN)
    ) u_extract (
      .value (pipe_value[int'(win)*RES_W +: RES_W]),
      .base  (pipe_base[int'(win)*ADDR_W +: ADDR_W]),
      .index (pipe_index[int'(win)*IDX_W +: IDX_W]),
      .size  (pipe_size[int'(win)*SIZE_W +: SIZE_W]),
      .dest  (dest),
      .word  (word)
    );

    assign rf_rd_addr[s*ADDR_W +: ADDR_W] = dest;
    assign rf_wr_req[s]  = any;
    assign commit_ev[s]  = any && rf_wr_gnt[s] && tag_accepts(rf_rd_tag[s*2 +: 2]);
    assign grant_mat[s]  = gsel & {NUM_PIPES{commit_ev[s]}};
    assign rf_wr_tag[s*2 +: 2] = TAG_FULL;

    wb_commit_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_commit (
      .clk     (clk),
      .rst_n   (rst_n),
      .commit  (commit_ev[s]),
      .addr    (dest),
      .word    (word),
      .wr_en   (rf_wr_en[s]),
      .wr_addr (rf_wr_addr[s*ADDR_W +: ADDR_W]),
      .wr_data (rf_wr_data[s*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    pipe_ready = '0;
    for (int s = 0; s < NUM_SOURCES; s++) begin
      pipe_ready = pipe_ready | grant_mat[s];
    end
  end

endmodule

// File: rtl/wb_writeback_checker.sv
module wb_writeback_checker #(
  parameter int NUM_PIPES   = 3,
  parameter int NUM_SOURCES = 2,
  localparam int SRC_W = (NUM_SOURCES > 1) ? $clog2(NUM_SOURCES) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_PIPES-1:0]       pipe_valid,
  input logic [NUM_PIPES*SRC_W-1:0] pipe_src,
  input logic [NUM_PIPES-1:0]       pipe_ready,
  input logic [NUM_SOURCES*2-1:0]   rf_rd_tag,
  input logic [NUM_SOURCES-1:0]     rf_wr_gnt,
  input logic [NUM_SOURCES-1:0]     rf_wr_en
);
  import wb_pkg::*;

  logic [NUM_PIPES-1:0]   rdy_on [NUM_SOURCES];
  logic [NUM_SOURCES-1:0] acc;
  logic [NUM_PIPES-1:0]   lower_busy;

  always_comb begin
    for (int s = 0; s < NUM_SOURCES; s++) begin
      for (int p = 0; p < NUM_PIPES; p++) begin
        rdy_on[s][p] = pipe_ready[p] && (pipe_src[p*SRC_W +: SRC_W] == SRC_W'(s));
      end
      acc[s] = |rdy_on[s];
    end
    for (int p = 0; p < NUM_PIPES; p++) begin
      lower_busy[p] = 1'b0;
      for (int q = 0; q < p; q++) begin
        if (pipe_valid[q] && (pipe_src[q*SRC_W +: SRC_W] == pipe_src[p*SRC_W +: SRC_W]))
          lower_busy[p] = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NUM_SOURCES; s++) begin : g_src_chk
    assert_port_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc[s] |-> rf_wr_gnt[s]);
    assert_tag_expecting_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc[s] |-> tag_accepts(rf_rd_tag[s*2 +: 2]));
    assert_one_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rdy_on[s]) <= 1);
    assert_write_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc[s] |=> rf_wr_en[s]);
    assert_write_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en[s] |-> $past(acc[s]));
  end

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe_chk
    assert_ready_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_ready[p] |-> pipe_valid[p]);
    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_ready[p] |-> !lower_busy[p]);
  end

endmodule

bind fp_result_writeback wb_writeback_checker #(
  .NUM_PIPES(NUM_PIPES), .NUM_SOURCES(NUM_SOURCES)
) u_wb_chk (.*);

// File: tb/test_fp_result_writeback.sv
`timescale 1ns/1ps
module test_fp_result_writeback;
  localparam int P = 3, S = 2, WW = 32, MW = 4, AW = 6;
  localparam int SW = 1, IW = 2, ZW = 3, RW = WW * MW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [P-1:0]    pipe_valid;
  logic [P*SW-1:0] pipe_src;
  logic [P*AW-1:0] pipe_base;
  logic [P*IW-1:0] pipe_index;
  logic [P*ZW-1:0] pipe_size;
  logic [P*RW-1:0] pipe_value;
  logic [S-1:0]    gnt;
  logic [1:0]      tagmem [S][64];

  logic [P-1:0]    rdy_l, rdy_b;
  logic [S*AW-1:0] rda_l, rda_b, wa_l, wa_b;
  logic [S*2-1:0]  rdt_l, rdt_b, wt_l, wt_b;
  logic [S-1:0]    wrq_l, wrq_b, we_l, we_b;
  logic [S*WW-1:0] wd_l, wd_b;

  for (genvar s = 0; s < S; s++) begin : g_tag
    assign rdt_l[s*2 +: 2] = tagmem[s][rda_l[s*AW +: AW]];
    assign rdt_b[s*2 +: 2] = tagmem[s][rda_b[s*AW +: AW]];
  end

  fp_result_writeback #(.BIG_ENDIAN(1'b0)) i_fp_result_writeback (
    .clk(clk), .rst_n(rst_n), .pipe_valid(pipe_valid), .pipe_src(pipe_src),
    .pipe_base(pipe_base), .pipe_index(pipe_index), .pipe_size(pipe_size),
    .pipe_value(pipe_value), .pipe_ready(rdy_l), .rf_rd_addr(rda_l),
    .rf_rd_tag(rdt_l), .rf_wr_req(wrq_l), .rf_wr_gnt(gnt), .rf_wr_en(we_l),
    .rf_wr_addr(wa_l), .rf_wr_data(wd_l), .rf_wr_tag(wt_l));

  fp_result_writeback #(.BIG_ENDIAN(1'b1)) i_fp_result_writeback_be (
    .clk(clk), .rst_n(rst_n), .pipe_valid(pipe_valid), .pipe_src(pipe_src),
    .pipe_base(pipe_base), .pipe_index(pipe_index), .pipe_size(pipe_size),
    .pipe_value(pipe_value), .pipe_ready(rdy_b), .rf_rd_addr(rda_b),
    .rf_rd_tag(rdt_b), .rf_wr_req(wrq_b), .rf_wr_gnt(gnt), .rf_wr_en(we_b),
    .rf_wr_addr(wa_b), .rf_wr_data(wd_b), .rf_wr_tag(wt_b));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected word: slice the value at the effective word position.
  function automatic logic [WW-1:0] exp_word(input logic [RW-1:0] v, input int idx,
                                             input int sz, input bit be);
    int e;
    e = be ? (sz - 1 - idx) : idx;
    return v[e*WW +: WW];
  endfunction

  logic [P-1:0]  e_rdy;
  logic [S-1:0]  e_req, e_commit;
  logic [AW-1:0] e_addr [S];
  logic [WW-1:0] e_dl [S], e_db [S];

  task automatic expect_now();
    for (int s = 0; s < S; s++) begin
      int w;
      w = -1;
      for (int p = P - 1; p >= 0; p--)
        if (pipe_valid[p] && pipe_src[p] == s[0]) w = p;
      e_req[s] = (w >= 0);
      e_commit[s] = 1'b0;
      e_addr[s] = '0;
      if (w >= 0) begin
        int ix, sz;
        ix = int'(pipe_index[w*IW +: IW]);
        sz = int'(pipe_size[w*ZW +: ZW]);
        e_addr[s] = AW'(int'(pipe_base[w*AW +: AW]) + ix);
        e_dl[s] = exp_word(pipe_value[w*RW +: RW], ix, sz, 1'b0);
        e_db[s] = exp_word(pipe_value[w*RW +: RW], ix, sz, 1'b1);
        e_commit[s] = gnt[s] && (tagmem[s][e_addr[s]] == 2'd1 || tagmem[s][e_addr[s]] == 2'd2);
      end
    end
    for (int p = 0; p < P; p++) begin
      e_rdy[p] = 1'b0;
      for (int s = 0; s < S; s++) begin
        if (pipe_valid[p] && pipe_src[p] == s[0] && e_commit[s]) begin
          bit lower;
          lower = 1'b0;
          for (int q = 0; q < p; q++)
            if (pipe_valid[q] && pipe_src[q] == s[0]) lower = 1'b1;
          e_rdy[p] = !lower;
        end
      end
    end
  endtask

  // Inputs were just driven after a falling edge.
  task automatic run_vec();
    #1;
    expect_now();
    chk(rdy_l == e_rdy && rdy_b == e_rdy, "R6 pipe_ready", {rdy_b, rdy_l}, {e_rdy, e_rdy});
    chk(wrq_l == e_req && wrq_b == e_req, "R5 rf_wr_req", {wrq_b, wrq_l}, {e_req, e_req});
    for (int s = 0; s < S; s++)
      if (e_req[s])
        chk(rda_l[s*AW +: AW] == e_addr[s], "R1 rf_rd_addr", rda_l[s*AW +: AW], e_addr[s]);
    @(negedge clk);
    chk(we_l == e_commit && we_b == e_commit, "R8 rf_wr_en", {we_b, we_l}, {e_commit, e_commit});
    for (int s = 0; s < S; s++) begin
      if (e_commit[s]) begin
        chk(wa_l[s*AW +: AW] == e_addr[s] && wa_b[s*AW +: AW] == e_addr[s], "R1 rf_wr_addr",
            wa_l[s*AW +: AW], e_addr[s]);
        chk(wd_l[s*WW +: WW] == e_dl[s], "R2 little-endian word", wd_l[s*WW +: WW], e_dl[s]);
        chk(wd_b[s*WW +: WW] == e_db[s], "R3 big-endian word", wd_b[s*WW +: WW], e_db[s]);
        chk(wt_l[s*2 +: 2] == 2'd3 && wt_b[s*2 +: 2] == 2'd3, "R8 rf_wr_tag FULL",
            {wt_b[s*2 +: 2], wt_l[s*2 +: 2]}, 4'hF);
      end
    end
  endtask

  task automatic set_pipe(input int p, input bit v, input int src, input int base,
                          input int idx, input int sz);
    pipe_valid[p] = v;
    pipe_src[p] = src[0];
    pipe_base[p*AW +: AW] = AW'(base);
    pipe_index[p*IW +: IW] = IW'(idx);
    pipe_size[p*ZW +: ZW] = ZW'(sz);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    pipe_valid = '0; pipe_src = '0; pipe_base = '0; pipe_index = '0;
    pipe_size = '0; gnt = '1;
    for (int k = 0; k < P * MW; k++) pipe_value[k*WW +: WW] = 32'h1000_0000 + k * 32'h0101_0101;
    for (int s = 0; s < S; s++) for (int a = 0; a < 64; a++) tagmem[s][a] = 2'd1;

    // R9: reset holds the write port quiet even with traffic offered
    set_pipe(0, 1, 0, 5, 0, 1);
    set_pipe(1, 1, 1, 9, 0, 1);
    repeat (3) @(negedge clk);
    chk(we_l == '0 && we_b == '0, "R9 reset write strobe", {we_b, we_l}, 0);
    pipe_valid = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(we_l == '0, "R9 idle after reset", we_l, 0);

    // R5: write port refused
    set_pipe(0, 1, 0, 10, 1, 2);
    gnt = 2'b10;
    run_vec();
    chk(rdy_l[0] == 1'b0, "R5 stall without grant", rdy_l, 0);
    gnt = '1;

    // R4: EMPTY and FULL destinations stall
    tagmem[0][11] = 2'd0;
    run_vec();
    tagmem[0][11] = 2'd3;
    run_vec();
    tagmem[0][11] = 2'd2;
    run_vec();

    // R6: lowest valid pipe on a shared source wins
    set_pipe(0, 0, 0, 0, 0, 1);
    set_pipe(1, 1, 0, 20, 2, 4);
    set_pipe(2, 1, 0, 30, 0, 1);
    run_vec();
    chk(rdy_l == 3'b010, "R6 pipe 1 wins", rdy_l, 3'b010);

    // R7: distinct sources in the same cycle; R3 size-4 word 0 is top word
    set_pipe(0, 1, 0, 40, 0, 4);
    set_pipe(1, 1, 1, 50, 3, 4);
    set_pipe(2, 0, 0, 0, 0, 1);
    run_vec();

    // Constrained random traffic
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < P; p++) begin
        int sz;
        sz = 1 + int'($urandom % MW);
        set_pipe(p, ($urandom % 10) < 7, int'($urandom % S), int'($urandom % 64),
                 int'($urandom % sz), sz);
        for (int k = 0; k < MW; k++) pipe_value[(p*MW + k)*WW +: WW] = $urandom;
      end
      gnt = S'($urandom);
      if (($urandom % 4) != 0) gnt = '1;
      for (int s = 0; s < S; s++) for (int a = 0; a < 64; a++) tagmem[s][a] = 2'($urandom);
      run_vec();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule